// File: doc/BRIEF.md
# Trace Message Queue with Overflow Recovery

This block buffers trace messages from two producers, a data trace source and a watchpoint source, and passes them to a single drain port. Producers have no back-pressure. Each one presents a message with a valid strobe, and the queue either stores it or loses it. Message contents are opaque to the queue. The one exception is the error entry that the queue creates itself.

When a message cannot be stored, the queue enters a recovery state. In that state it refuses every new message until its storage has drained completely. It then writes a single error entry whose code tells the consumer which producers lost messages. Only after that does normal intake resume.

The two producers share one write slot per cycle, and the watchpoint producer has priority. A one-entry holding register keeps a data message that lost that slot, and writes it on a later cycle.

Top module: `trace_ovf_queue`

## Requirements
- R1: After reset `out_valid`, `ovf_active` and `q_count` are all 0.
- R2: Stored messages leave `out_msg` in arrival order. `out_valid` is high whenever `q_count` is nonzero. A message is removed on a clock edge where `out_valid` and `out_ready` are both high, and the head stays stable while it is not removed.
- R3: When both producers are valid in a non-recovery cycle with room in the queue, the watchpoint message is written in that cycle. The data message is held and is written on a following cycle, ahead of any later data message.
- R4: A message presented while `q_count` equals DEPTH is not stored, even if a pop occurs in the same cycle. `ovf_active` rises on that edge, and the lost message counts toward the error code.
- R5: While `ovf_active` is high, every message from either producer is discarded, including while `q_count` falls but is still nonzero.
- R6: In a recovery cycle where `q_count` is 0, an error entry is written and `ovf_active` falls on the same edge. The entry has bits [10:5] = 6'b001000, bits [4:0] = the error code, and all higher bits zero.
- R7: The error code is 5'b00010 when only data messages were lost during the recovery episode.
- R8: The error code is 5'b01000 when at least one watchpoint message was lost during the episode. This includes a watchpoint presented in the cycle the error entry is written.
- R9: The lost-source record is cleared when the error entry is written, so a later episode's code reflects only that episode's losses.
- R10: Entering recovery discards a held data message. If a watchpoint, a held data message and a new data message all arrive together, the watchpoint is stored, both data messages are lost, and recovery begins.
- R11: From the cycle after the error entry is written, new messages are accepted normally again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_valid | input | 1 | Watchpoint message present |
| wp_msg | input | MSG_W | Watchpoint message |
| dt_valid | input | 1 | Data trace message present |
| dt_msg | input | MSG_W | Data trace message |
| out_valid | output | 1 | Head entry available |
| out_ready | input | 1 | Consumer takes head entry |
| out_msg | output | MSG_W | Head entry |
| ovf_active | output | 1 | Recovery state in progress |
| q_count | output | $clog2(DEPTH+1) | Stored entry count |

## Verification
A lost-source record that is set wrongly shows up only when an error entry reaches the head of the queue. That can be up to DEPTH pops after the loss, so the bench follows every overflow through to the error entry and compares its code. A held data message that is lost or duplicated shifts the order of every later entry on `out_msg`, so it is seen at the next pop. A recovery state that ends early or late shows within one cycle on `ovf_active` and `q_count`.

// File: rtl/trace_ovf_pkg.sv
package trace_ovf_pkg;
  localparam int ERR_W = 11;
  localparam logic [5:0] TC_ERR     = 6'b001000;
  localparam logic [4:0] EC_DATA    = 5'b00010;
  localparam logic [4:0] EC_WATCH   = 5'b01000;

  function automatic logic [ERR_W-1:0] err_entry(input logic watch_lost);
    return {TC_ERR, (watch_lost ? EC_WATCH : EC_DATA)};
  endfunction
endpackage

// File: rtl/trace_ovf_fifo.sv
module trace_ovf_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign count   = cnt;
  assign full    = (cnt == FULL_CNT);
  assign empty   = (cnt == '0);
endmodule

// File: rtl/trace_ovf_ctrl.sv
module trace_ovf_ctrl
  import trace_ovf_pkg::*;
#(
  parameter int MSG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wp_valid,
  input  logic [MSG_W-1:0] wp_msg,
  input  logic             dt_valid,
  input  logic [MSG_W-1:0] dt_msg,
  input  logic             q_full,
  input  logic             q_empty,
  output logic             push,
  output logic [MSG_W-1:0] push_data,
  output logic             ovf_active
);
  logic             hold_v, hold_v_n;
  logic [MSG_W-1:0] hold_d, hold_d_n;
  logic             ovf, ovf_n;
  logic             wlost, wlost_n;

  always_comb begin
    push      = 1'b0;
    push_data = wp_msg;
    hold_v_n  = hold_v;
    hold_d_n  = hold_d;
    ovf_n     = ovf;
    wlost_n   = wlost;
    if (ovf) begin
      wlost_n = wlost | wp_valid;
      if (q_empty) begin
        push      = 1'b1;
        push_data = {{(MSG_W-ERR_W){1'b0}}, err_entry(wlost | wp_valid)};
        ovf_n     = 1'b0;
        wlost_n   = 1'b0;
      end
    end else if (wp_valid || hold_v || dt_valid) begin
      if (q_full) begin
        ovf_n    = 1'b1;
        wlost_n  = wp_valid;
        hold_v_n = 1'b0;
      end else begin
        push = 1'b1;
        if (wp_valid)    push_data = wp_msg;
        else if (hold_v) push_data = hold_d;
        else             push_data = dt_msg;
        if (dt_valid && (wp_valid || hold_v)) begin
          if (wp_valid && hold_v) begin
            ovf_n    = 1'b1;
            hold_v_n = 1'b0;
          end else begin
            hold_v_n = 1'b1;
            hold_d_n = dt_msg;
          end
        end else if (!wp_valid && hold_v) begin
          hold_v_n = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v <= 1'b0;
      ovf    <= 1'b0;
      wlost  <= 1'b0;
    end else begin
      hold_v <= hold_v_n;
      ovf    <= ovf_n;
      wlost  <= wlost_n;
    end
  end

  always_ff @(posedge clk) hold_d <= hold_d_n;

  assign ovf_active = ovf;
endmodule

// File: rtl/trace_ovf_queue.sv
module trace_ovf_queue #(
  parameter int DEPTH = 8,
  parameter int MSG_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wp_valid,
  input  logic [MSG_W-1:0]           wp_msg,
  input  logic                       dt_valid,
  input  logic [MSG_W-1:0]           dt_msg,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [MSG_W-1:0]           out_msg,
  output logic                       ovf_active,
  output logic [$clog2(DEPTH+1)-1:0] q_count
);
  logic             push, q_full, q_empty;
  logic [MSG_W-1:0] push_data;

  trace_ovf_ctrl #(.MSG_W(MSG_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .wp_valid(wp_valid), .wp_msg(wp_msg),
    .dt_valid(dt_valid), .dt_msg(dt_msg),
    .q_full(q_full), .q_empty(q_empty),
    .push(push), .push_data(push_data),
    .ovf_active(ovf_active)
  );

  trace_ovf_fifo #(.DEPTH(DEPTH), .W(MSG_W)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push), .push_data(push_data),
    .pop(out_valid && out_ready),
    .rd_data(out_msg), .count(q_count),
    .full(q_full), .empty(q_empty)
  );

  assign out_valid = !q_empty;
endmodule

// File: rtl/trace_ovf_queue_chk.sv
module trace_ovf_queue_chk #(
  parameter int DEPTH = 8,
  parameter int MSG_W = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wp_valid,
  input logic [MSG_W-1:0]           wp_msg,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [MSG_W-1:0]           out_msg,
  input logic                       ovf_active,
  input logic [$clog2(DEPTH+1)-1:0] q_count,
  input logic                       push,
  input logic [MSG_W-1:0]           push_data
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (q_count == '0) && !ovf_active && !out_valid); // R1
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst) out_valid && !out_ready |=> out_valid && $stable(out_msg)); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) q_count <= FULL_CNT); // R2
  AST_WATCH_FIRST: assert property (@(posedge clk) disable iff (rst) !ovf_active && wp_valid && (q_count != FULL_CNT) |-> push && (push_data == wp_msg)); // R3
  AST_FULL_ENTERS: assert property (@(posedge clk) disable iff (rst) !ovf_active && wp_valid && (q_count == FULL_CNT) |=> ovf_active); // R4
  AST_NO_INTAKE: assert property (@(posedge clk) disable iff (rst) ovf_active && (q_count != '0) |-> !push); // R5
  AST_ERR_FORMAT: assert property (@(posedge clk) disable iff (rst) ovf_active && (q_count == '0) |-> push && (push_data[10:5] == 6'b001000) && (push_data[MSG_W-1:11] == '0)); // R6
  AST_ERR_EXIT: assert property (@(posedge clk) disable iff (rst) ovf_active && (q_count == '0) |=> !ovf_active); // R6
  AST_ERR_WATCH: assert property (@(posedge clk) disable iff (rst) ovf_active && (q_count == '0) && wp_valid |-> push_data[4:0] == 5'b01000); // R8
endmodule

bind trace_ovf_queue trace_ovf_queue_chk #(.DEPTH(DEPTH), .MSG_W(MSG_W)) u_chk (
  .clk(clk), .rst(rst), .wp_valid(wp_valid), .wp_msg(wp_msg),
  .out_valid(out_valid), .out_ready(out_ready), .out_msg(out_msg),
  .ovf_active(ovf_active), .q_count(q_count),
  .push(push), .push_data(push_data)
);

// File: tb/trace_ovf_queue_tb.sv
`timescale 1ns/1ps
module trace_ovf_queue_tb;
  localparam int DEPTH = 8;
  localparam int MSG_W = 32;
  localparam int CW = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp_valid = 1'b0, dt_valid = 1'b0, out_ready = 1'b0;
  logic [MSG_W-1:0] wp_msg = '0, dt_msg = '0;
  logic out_valid, ovf_active;
  logic [MSG_W-1:0] out_msg;
  logic [CW-1:0] q_count;

  always #4 clk = ~clk;

  trace_ovf_queue #(.DEPTH(DEPTH), .MSG_W(MSG_W)) u_dut (
    .clk(clk), .rst(rst), .wp_valid(wp_valid), .wp_msg(wp_msg),
    .dt_valid(dt_valid), .dt_msg(dt_msg), .out_valid(out_valid),
    .out_ready(out_ready), .out_msg(out_msg), .ovf_active(ovf_active),
    .q_count(q_count)
  );

  int errors = 0, checks = 0, cycles = 0;
  string cur_tag = "R1";
  logic [23:0] seq = '0;

  logic [MSG_W-1:0] mq[$];
  bit               me[$];
  bit               m_hold_v, m_ovf, m_wlost;
  logic [MSG_W-1:0] m_hold_d;

  function automatic logic [MSG_W-1:0] exp_err(input bit watch);
    return {21'b0, 6'b001000, (watch ? 5'b01000 : 5'b00010)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [MSG_W-1:0] act, input logic [MSG_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(out_valid == (mq.size() != 0), cur_tag, MSG_W'(out_valid), MSG_W'(mq.size() != 0));
    chk(q_count == CW'(mq.size()), cur_tag, MSG_W'(q_count), MSG_W'(mq.size()));
    chk(ovf_active == m_ovf, cur_tag, MSG_W'(ovf_active), MSG_W'(m_ovf));
    if (mq.size() != 0) begin
      if (me[0]) begin
        chk(out_msg[10:5] == 6'b001000, "R6", out_msg, mq[0]);
        chk(out_msg == mq[0], (mq[0][4:0] == 5'b01000) ? "R8" : "R7", out_msg, mq[0]);
      end else begin
        chk(out_msg == mq[0], cur_tag, out_msg, mq[0]);
      end
    end
  endtask

  task automatic model_push(input logic [MSG_W-1:0] v, input bit e);
    mq.push_back(v);
    me.push_back(e);
  endtask

  task automatic model_step();
    bit pop;
    pop = (mq.size() != 0) && out_ready;
    if (pop) begin
      void'(mq.pop_front());
      void'(me.pop_front());
    end
    if (m_ovf) begin
      m_wlost = m_wlost | wp_valid;
      if (mq.size() + (pop ? 1 : 0) == 0) begin
        model_push(exp_err(m_wlost), 1'b1);
        m_ovf = 0;
        m_wlost = 0;
      end
    end else if (wp_valid || m_hold_v || dt_valid) begin
      if (mq.size() + (pop ? 1 : 0) == DEPTH) begin
        m_ovf = 1;
        m_wlost = wp_valid;
        m_hold_v = 0;
      end else begin
        bit had_hold;
        had_hold = m_hold_v;
        if (wp_valid) model_push(wp_msg, 0);
        else if (m_hold_v) begin model_push(m_hold_d, 0); m_hold_v = 0; end
        else model_push(dt_msg, 0);
        if (dt_valid && (wp_valid || had_hold)) begin
          if (m_hold_v) begin
            m_ovf = 1;
            m_hold_v = 0;
          end else begin
            m_hold_v = 1;
            m_hold_d = dt_msg;
          end
        end
      end
    end
  endtask

  task automatic cyc(input bit wv, input bit dv, input bit rdy);
    @(negedge clk);
    compare();
    seq = seq + 1'b1;
    wp_valid = wv;
    dt_valid = dv;
    wp_msg = {8'hA5, seq};
    dt_msg = {8'h3C, seq};
    out_ready = rdy;
    model_step();
  endtask

  task automatic run(input int n, input bit wv, input bit dv, input bit rdy);
    for (int i = 0; i < n; i++) cyc(wv, dv, rdy);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<200000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_hold_v = 0; m_ovf = 0; m_wlost = 0; m_hold_d = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cur_tag = "R1";
    @(negedge clk);
    chk(!out_valid && !ovf_active && q_count == '0, "R1",
        MSG_W'({out_valid, ovf_active, q_count}), '0);

    cur_tag = "R2";
    run(5, 0, 1, 0);
    run(3, 0, 0, 1);
    run(4, 0, 1, 1);
    run(4, 0, 0, 1);

    cur_tag = "R3";
    cyc(1, 1, 0);
    cyc(0, 0, 0);
    cyc(1, 1, 0);
    cyc(0, 1, 0);
    run(6, 0, 0, 1);

    cur_tag = "R4";
    run(DEPTH, 0, 1, 0);
    cyc(0, 1, 1);
    cur_tag = "R5";
    run(DEPTH + 4, 0, 1, 1);
    cur_tag = "R11";
    run(4, 0, 1, 1);
    run(3, 0, 0, 1);

    cur_tag = "R8";
    run(DEPTH, 0, 1, 0);
    cyc(0, 1, 0);
    run(3, 0, 1, 1);
    cyc(1, 0, 1);
    run(DEPTH + 2, 0, 1, 1);
    run(3, 0, 0, 1);

    cur_tag = "R9";
    run(DEPTH, 0, 1, 0);
    cyc(1, 0, 0);
    run(DEPTH + 3, 0, 0, 1);
    run(DEPTH, 0, 1, 0);
    cyc(0, 1, 0);
    run(DEPTH + 3, 0, 1, 1);
    run(2, 0, 0, 1);

    cur_tag = "R10";
    cyc(1, 1, 1);
    cyc(1, 1, 1);
    run(6, 0, 0, 1);
    run(DEPTH - 1, 1, 1, 0);
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    run(DEPTH + 4, 0, 0, 1);

    cur_tag = "R2";
    for (int i = 0; i < 3000; i++)
      cyc(($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1), ($urandom_range(0, 9) < 6));
    run(DEPTH + 4, 0, 0, 1);
    @(negedge clk);
    compare();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule